// File: doc/BRIEF.md
# Paced Multiplexed-Bus Cycle Master

This block is a bus master that runs one memory or I/O transfer at a time on a classic 8-bit multiplexed bus. The bus has a 20-bit address whose low byte shares pins with data, three active-low status lines that announce the kind of cycle, and two queue-status lines. A client presents a single command: address, direction, memory or I/O space, and write data. The block turns that command into a complete bus cycle, adds wait states while the addressed device holds READY low, and hands read data back with a one-clock completion pulse. The block is clocked directly by the bus clock.

The block never starts cycles back to back. The address is placed on the pins while the bus is still idle and the status lines still show the passive code. Only after that does the status change, and that change is what starts the transfer. Devices downstream therefore see an address that has already settled, and they ignore the address pins while the status is passive. After each cycle the bus returns to idle for at least two clocks before the next status assertion.

Top module: `mux_bus_master`

## Requirements
- R1: `req_ready` is high only in the idle state, and `bus_stat_n` is 111 whenever it is high. A command is taken when `req_valid` is high at a rising edge while `req_ready` is high. Command inputs presented during a cycle are ignored and do not disturb the address pins.
- R2: In the clock after a command is accepted, the status stays passive (111) while the full address is driven: `bus_a_hi` = address[19:8], `bus_ad_out` = address[7:0], `bus_ad_oe` = 1. In the next clock (T1) the status becomes active and the address is unchanged.
- R3: `bus_stat_n[2:0]` carries 101 for memory read, 110 for memory write, 001 for I/O read and 010 for I/O write. It carries 111 when passive, and no other value ever appears.
- R4: With READY high, the status is active for exactly three clocks (T1, T2, T3) and then passive in T4. T1 to T4 spans four clocks.
- R5: `bus_rdy` is sampled at the edge that ends T3 and at the edge that ends each wait clock. Each low sample adds one more clock with the status still active.
- R6: On a read, `bus_ad_oe` is low from T2 through T4. `bus_ad_in` is captured at the edge that ends the last T3 or wait clock and appears on `rsp_rdata`.
- R7: On a write, `bus_ad_out` carries the write data with `bus_ad_oe` high from T2 through T4. In the idle clock that follows, the pins return to the address low byte.
- R8: `rsp_done` is high for exactly the one clock that follows T4, for both reads and writes. `rsp_rdata` keeps its last read value across write cycles.
- R9: After T4, at least two further passive clocks (idle, then address setup) pass before the next active status.
- R10: For I/O cycles, address bits 19:16 are driven as zero and only the low 16 bits of the command address are used.
- R11: `bus_qstat` is 00 at all times.
- R12: After reset the status is 111, `req_ready` is 1, `rsp_done` is 0, `rsp_rdata` is 0 and `bus_ad_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_addr | input | 20 | Command address |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Idle; a command may be taken |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 8 | Last captured read data |
| bus_a_hi | output | 12 | Address bits 19:8 |
| bus_ad_out | output | 8 | Multiplexed address low byte / write data |
| bus_ad_oe | output | 1 | Output enable for the multiplexed pins |
| bus_ad_in | input | 8 | Read data from the multiplexed pins |
| bus_stat_n | output | 3 | Active-low status code |
| bus_qstat | output | 2 | Queue status, always 00 |
| bus_rdy | input | 1 | Device ready; low inserts wait clocks |

## Verification
The bench builds the block with the default widths: a 20-bit address, an 8-bit multiplexed byte and a 16-bit I/O space. These values place the I/O zeroing on the exact nibble 19:16 and let address values such as FFFFF and ABCDE show any leak of upper bits. Wait counts from zero to five, and read data that changes right after the capture edge, test both the READY sampling point and the data capture edge. Commands issued straight after a completion test the minimum idle spacing between cycles.

// File: rtl/mux_bus_master.sv
module mux_bus_master #(
  parameter int ADDR_W = 20,
  parameter int LOW_W  = 8,
  parameter int IO_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_io,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LOW_W-1:0]  req_wdata,
  output logic              req_ready,
  output logic              rsp_done,
  output logic [LOW_W-1:0]  rsp_rdata,
  output logic [ADDR_W-LOW_W-1:0] bus_a_hi,
  output logic [LOW_W-1:0]  bus_ad_out,
  output logic              bus_ad_oe,
  input  logic [LOW_W-1:0]  bus_ad_in,
  output logic [2:0]        bus_stat_n,
  output logic [1:0]        bus_qstat,
  input  logic              bus_rdy
);
  localparam int HI_W  = ADDR_W - LOW_W;
  localparam int PAD_W = ADDR_W - IO_W;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_T1, ST_T2, ST_T3, ST_TW, ST_T4
  } st_t;

  st_t              st, st_nx;
  logic [ADDR_W-1:0] addr_q;
  logic [LOW_W-1:0]  wdata_q, rdata_q;
  logic              wr_q, io_q, done_q;
  logic              active, data_phase, last_wait;

  always_comb begin
    st_nx = st;
    case (st)
      ST_IDLE:  if (req_valid) st_nx = ST_SETUP;
      ST_SETUP: st_nx = ST_T1;
      ST_T1:    st_nx = ST_T2;
      ST_T2:    st_nx = ST_T3;
      ST_T3,
      ST_TW:    st_nx = bus_rdy ? ST_T4 : ST_TW;
      ST_T4:    st_nx = ST_IDLE;
      default:  st_nx = ST_IDLE;
    endcase
  end

  assign active     = (st == ST_T1) || (st == ST_T2) || (st == ST_T3) || (st == ST_TW);
  assign data_phase = (st == ST_T2) || (st == ST_T3) || (st == ST_TW) || (st == ST_T4);
  assign last_wait  = ((st == ST_T3) || (st == ST_TW)) && bus_rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      wr_q    <= 1'b0;
      io_q    <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      st     <= st_nx;
      done_q <= (st == ST_T4);
      if (st == ST_IDLE && req_valid) begin
        addr_q  <= req_io ? {{PAD_W{1'b0}}, req_addr[IO_W-1:0]} : req_addr;
        wdata_q <= req_wdata;
        wr_q    <= req_write;
        io_q    <= req_io;
      end
      if (last_wait && !wr_q) rdata_q <= bus_ad_in;
    end
  end

  assign req_ready  = (st == ST_IDLE);
  assign rsp_done   = done_q;
  assign rsp_rdata  = rdata_q;
  assign bus_a_hi   = addr_q[ADDR_W-1 -: HI_W];
  assign bus_ad_out = (wr_q && data_phase) ? wdata_q : addr_q[LOW_W-1:0];
  assign bus_ad_oe  = wr_q || !data_phase;
  assign bus_stat_n = active ? {!io_q, wr_q, !wr_q} : 3'b111;
  assign bus_qstat  = 2'b00;
endmodule

// File: rtl/mux_bus_master_chk.sv
module mux_bus_master_chk #(
  parameter int ADDR_W = 20,
  parameter int LOW_W  = 8,
  parameter int IO_W   = 16
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_ready,
  input logic                    rsp_done,
  input logic [ADDR_W-LOW_W-1:0] bus_a_hi,
  input logic [LOW_W-1:0]        bus_ad_out,
  input logic                    bus_ad_oe,
  input logic [2:0]              bus_stat_n,
  input logic                    bus_rdy
);
  localparam int HI_W  = ADDR_W - LOW_W;
  localparam int PAD_W = ADDR_W - IO_W;

  logic act, is_rd, is_wr, is_io;
  assign act   = bus_stat_n != 3'b111;
  assign is_rd = (bus_stat_n == 3'b101) || (bus_stat_n == 3'b001);
  assign is_wr = (bus_stat_n == 3'b110) || (bus_stat_n == 3'b010);
  assign is_io = (bus_stat_n == 3'b001) || (bus_stat_n == 3'b010);

  p_ready_passive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> bus_stat_n == 3'b111);

  p_addr_settled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (act && $past(bus_stat_n) == 3'b111) |->
      ($stable(bus_a_hi) && $stable(bus_ad_out) && bus_ad_oe && $past(bus_ad_oe)));

  p_legal_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
    act |-> (is_rd || is_wr));

  p_wait_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (act && !bus_rdy) |=> act);

  p_read_float_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (is_rd && $past(bus_stat_n) == bus_stat_n) |-> !bus_ad_oe);

  p_write_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr |-> bus_ad_oe);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  p_idle_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!act && $past(act)) |=> !act);

  p_io_upper_r10: assert property (@(posedge clk) disable iff (!rst_n)
    is_io |-> bus_a_hi[HI_W-1 -: PAD_W] == '0);
endmodule

bind mux_bus_master mux_bus_master_chk #(
  .ADDR_W(ADDR_W), .LOW_W(LOW_W), .IO_W(IO_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .rsp_done(rsp_done),
  .bus_a_hi(bus_a_hi), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
  .bus_stat_n(bus_stat_n), .bus_rdy(bus_rdy)
);

// File: tb/mux_bus_master_tb_top.sv
module mux_bus_master_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0;
  logic [19:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_done;
  logic [7:0]  rsp_rdata;
  logic [11:0] bus_a_hi;
  logic [7:0]  bus_ad_out;
  logic        bus_ad_oe;
  logic [7:0]  bus_ad_in = '0;
  logic [2:0]  bus_stat_n;
  logic [1:0]  bus_qstat;
  logic        bus_rdy = 1'b1;

  int n_chk = 0, n_fail = 0;
  logic [7:0] last_rd = '0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_master dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_io(req_io), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_ready(req_ready), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .bus_a_hi(bus_a_hi), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
    .bus_ad_in(bus_ad_in), .bus_stat_n(bus_stat_n), .bus_qstat(bus_qstat),
    .bus_rdy(bus_rdy)
  );

  function automatic logic [2:0] exp_code(input bit wr, input bit io);
    if (io) return wr ? 3'b010 : 3'b001;
    return wr ? 3'b110 : 3'b101;
  endfunction

  function automatic logic [19:0] exp_addr(input bit io, input logic [19:0] a);
    return io ? {4'h0, a[15:0]} : a;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic txn(input bit wr, input bit io, input logic [19:0] a,
                     input logic [7:0] wd, input int waits, input logic [7:0] dd);
    logic [19:0] ea;
    logic [2:0]  ec;
    ea = exp_addr(io, a);
    ec = exp_code(wr, io);
    chk("R1 ready before command", 32'(req_ready), 32'(1));
    req_valid = 1; req_write = wr; req_io = io; req_addr = a; req_wdata = wd;
    bus_ad_in = ~dd;
    @(negedge clk);
    req_valid = 0;
    chk("R2 setup status passive", 32'(bus_stat_n), 32'(3'b111));
    chk("R2 setup addr hi", 32'(bus_a_hi), 32'(ea[19:8]));
    chk("R2 setup addr lo", 32'(bus_ad_out), 32'(ea[7:0]));
    chk("R2 setup oe", 32'(bus_ad_oe), 32'(1));
    chk("R1 busy not ready", 32'(req_ready), 32'(0));
    chk("R8 done low in setup", 32'(rsp_done), 32'(0));
    if (io) chk("R10 io upper zero", 32'(bus_a_hi[11:8]), 32'(0));
    @(negedge clk);
    chk("R3 T1 status code", 32'(bus_stat_n), 32'(ec));
    chk("R2 T1 addr hi", 32'(bus_a_hi), 32'(ea[19:8]));
    chk("R2 T1 addr lo", 32'(bus_ad_out), 32'(ea[7:0]));
    chk("R2 T1 oe", 32'(bus_ad_oe), 32'(1));
    @(negedge clk);
    chk("R4 T2 status", 32'(bus_stat_n), 32'(ec));
    if (wr) begin
      chk("R7 T2 oe", 32'(bus_ad_oe), 32'(1));
      chk("R7 T2 data", 32'(bus_ad_out), 32'(wd));
    end else chk("R6 T2 float", 32'(bus_ad_oe), 32'(0));
    req_valid = 1; req_addr = ~a; req_io = ~io; req_write = ~wr;
    @(negedge clk);
    req_valid = 0;
    chk("R1 busy command ignored", 32'(bus_a_hi), 32'(ea[19:8]));
    chk("R4 T3 status", 32'(bus_stat_n), 32'(ec));
    bus_rdy = (waits == 0);
    bus_ad_in = dd;
    for (int i = 0; i < waits; i++) begin
      @(negedge clk);
      chk("R5 wait clock status", 32'(bus_stat_n), 32'(ec));
      if (!wr) chk("R6 wait float", 32'(bus_ad_oe), 32'(0));
      bus_rdy = (i == waits - 1);
    end
    @(negedge clk);
    bus_ad_in = ~dd;
    bus_rdy = 1;
    chk("R4 T4 passive", 32'(bus_stat_n), 32'(3'b111));
    chk("R8 done low in T4", 32'(rsp_done), 32'(0));
    if (wr) begin
      chk("R7 T4 oe", 32'(bus_ad_oe), 32'(1));
      chk("R7 T4 data", 32'(bus_ad_out), 32'(wd));
    end else chk("R6 T4 float", 32'(bus_ad_oe), 32'(0));
    @(negedge clk);
    chk("R8 done pulse", 32'(rsp_done), 32'(1));
    if (wr) chk("R8 rdata kept over write", 32'(rsp_rdata), 32'(last_rd));
    else begin
      chk("R6 read data", 32'(rsp_rdata), 32'(dd));
      last_rd = dd;
    end
    chk("R7 pins back to address", 32'(bus_ad_out), 32'(ea[7:0]));
    chk("R7 oe back on", 32'(bus_ad_oe), 32'(1));
    chk("R9 idle passive", 32'(bus_stat_n), 32'(3'b111));
    chk("R11 qstat", 32'(bus_qstat), 32'(0));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [31:0] r;
    void'($urandom(32'd20170123));
    repeat (3) @(negedge clk);
    chk("R12 reset status", 32'(bus_stat_n), 32'(3'b111));
    chk("R12 reset ready", 32'(req_ready), 32'(1));
    chk("R12 reset done", 32'(rsp_done), 32'(0));
    chk("R12 reset rdata", 32'(rsp_rdata), 32'(0));
    chk("R12 reset oe", 32'(bus_ad_oe), 32'(1));
    chk("R11 reset qstat", 32'(bus_qstat), 32'(0));
    rst_n = 1;
    @(negedge clk);
    txn(0, 0, 20'hFFFFF, 8'h00, 0, 8'h5A);
    txn(1, 0, 20'h12345, 8'hC3, 0, 8'h00);
    txn(0, 1, 20'hABCDE, 8'h00, 2, 8'hA5);
    txn(1, 1, 20'hF0F0F, 8'h3C, 3, 8'h00);
    txn(0, 0, 20'h00000, 8'h00, 5, 8'hFF);
    txn(0, 0, 20'h80001, 8'h00, 1, 8'h01);
    for (int k = 0; k < 60; k++) begin
      logic [19:0] a;
      logic [7:0]  wd, dd;
      bit          wr, io;
      int          w;
      r = $urandom; a = r[19:0]; wr = r[20]; io = r[21];
      r = $urandom; wd = r[7:0]; dd = r[15:8]; w = int'(r[17:16]);
      txn(wr, io, a, wd, w, dd);
      if (r[24]) begin
        repeat (int'(r[26:25]) + 1) @(negedge clk);
        chk("R1 idle stays passive", 32'(bus_stat_n), 32'(3'b111));
        chk("R8 done only once", 32'(rsp_done), 32'(0));
      end
    end
    summary();
  end
endmodule